// File: doc/BRIEF.md
# ADC Window Monitor Comparator

This block watches the stream of finished conversion results from an analog-to-digital converter. Each result is compared against two programmable thresholds, a lower one and an upper one. A three-bit mode field selects which of five window tests applies, and one of those codes switches the monitor off. When a result passes the selected test, a sticky match flag is raised and a one-cycle interrupt pulse is sent to the interrupt controller.

A differential-mode input picks how results and thresholds are read. When it is set, all three values are two's-complement signed numbers. When it is clear, they are unsigned. The result arrives with a valid strobe and no ready signal. The block accepts a result in every cycle and never applies back-pressure, so the producer does not have to wait. Software clears the sticky flag through a write-one-to-clear pulse input.

Top module: `adc_window_monitor`

## Requirements
- R1: After reset, `match_flag_o` and `match_irq_o` are 0. Mode code 0 (disabled) never produces a match.
- R2: Mode code 1 matches when the result is strictly greater than the lower threshold.
- R3: Mode code 2 matches when the result is strictly less than the upper threshold.
- R4: Mode code 3 matches when the result is strictly greater than the lower threshold and strictly less than the upper threshold. A result equal to either threshold does not match.
- R5: Mode code 4 matches when the result is strictly greater than the upper threshold and strictly less than the lower threshold. This mode is meant for thresholds programmed with the lower one above the upper one.
- R6: Mode codes 5, 6 and 7 behave exactly like mode code 0.
- R7: When `diff_mode_i` is 1, the result and both thresholds compare as DATA_W-bit two's-complement values. When it is 0, they compare as unsigned values.
- R8: A match is evaluated only in a cycle where `res_valid_i` is 1. A result presented while `res_valid_i` is 0 changes neither output.
- R9: `match_irq_o` is 1 for exactly the one cycle after each accepted result that matches. Back-to-back matching results give back-to-back pulses. The pulse is 0 otherwise.
- R10: `match_flag_o` goes to 1 in the cycle after a matching result and stays at 1 until a cycle with `flag_clr_i` at 1, after which it reads 0. If a clear and a matching result arrive in the same cycle, the flag stays at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| res_valid_i | input | 1 | Result strobe. The result is accepted in every cycle it is high. |
| res_data_i | input | DATA_W | Conversion result |
| thr_lo_i | input | DATA_W | Lower threshold |
| thr_hi_i | input | DATA_W | Upper threshold |
| win_mode_i | input | 3 | Window mode code (0 to 7) |
| diff_mode_i | input | 1 | 1 selects signed comparison |
| flag_clr_i | input | 1 | Write-one-to-clear pulse for the match flag |
| match_flag_o | output | 1 | Sticky window match flag |
| match_irq_o | output | 1 | One-cycle match interrupt pulse |

## Verification
A wrong comparator or mode decode shows up one cycle after the offending result: the interrupt pulse is present when it should be absent, or absent when it should be present. The flag then carries that error forward until the next clear.

A stuck or wrongly cleared flag register shows on `match_flag_o` in the cycle after a clear or after an idle result. Because the flag is sampled every cycle, a wrong hold is caught within one cycle.

A wrong choice between signed and unsigned comparison only shows for values whose top bit is set. For that reason, the stimulus is steered toward threshold-adjacent values and negative numbers.

// File: rtl/adc_win_pkg.sv
package adc_win_pkg;

  typedef enum logic [2:0] {
    WIN_OFF          = 3'd0,
    WIN_ABOVE_LO     = 3'd1,
    WIN_BELOW_HI     = 3'd2,
    WIN_INSIDE       = 3'd3,
    WIN_SWAPPED_BAND = 3'd4
  } win_mode_e;

  typedef struct packed {
    logic gt;
    logic lt;
  } cmp_res_t;

  localparam int unsigned NUM_THR = 2;
  localparam int unsigned THR_LO  = 0;
  localparam int unsigned THR_HI  = 1;

endpackage

// File: rtl/adc_win_cmp.sv
module adc_win_cmp
  import adc_win_pkg::*;
#(
  parameter int unsigned DATA_W = 12
) (
  input  logic [DATA_W-1:0] val_i,
  input  logic [DATA_W-1:0] ref_i,
  input  logic              signed_en_i,
  output cmp_res_t          res_o
);
  localparam int unsigned EXT_W = DATA_W + 1;

  logic signed [EXT_W-1:0] val_x;
  logic signed [EXT_W-1:0] ref_x;

  // extending with the sign bit or a zero lets one signed compare serve both modes
  always_comb begin
    val_x    = {signed_en_i & val_i[DATA_W-1], val_i};
    ref_x    = {signed_en_i & ref_i[DATA_W-1], ref_i};
    res_o.gt = (val_x > ref_x);
    res_o.lt = (val_x < ref_x);
  end
endmodule

// File: rtl/adc_win_decode.sv
module adc_win_decode
  import adc_win_pkg::*;
(
  input  logic [2:0] mode_i,
  input  cmp_res_t   vs_lo_i,
  input  cmp_res_t   vs_hi_i,
  output logic       hit_o
);
  win_mode_e mode;

  always_comb begin
    mode = win_mode_e'(mode_i);
    case (mode)
      WIN_ABOVE_LO:     hit_o = vs_lo_i.gt;
      WIN_BELOW_HI:     hit_o = vs_hi_i.lt;
      WIN_INSIDE:       hit_o = vs_lo_i.gt & vs_hi_i.lt;
      WIN_SWAPPED_BAND: hit_o = vs_hi_i.gt & vs_lo_i.lt;
      default:          hit_o = 1'b0; // off and reserved codes
    endcase
  end
endmodule

// File: rtl/adc_win_flag.sv
module adc_win_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic event_i,
  input  logic clr_i,
  output logic flag_o,
  output logic irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_o <= 1'b0;
      irq_o  <= 1'b0;
    end else begin
      irq_o <= event_i;
      if (event_i)    flag_o <= 1'b1; // a new match outranks a clear
      else if (clr_i) flag_o <= 1'b0;
    end
  end
endmodule

// File: rtl/adc_window_monitor.sv
module adc_window_monitor
  import adc_win_pkg::*;
#(
  parameter int unsigned DATA_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              res_valid_i,
  input  logic [DATA_W-1:0] res_data_i,
  input  logic [DATA_W-1:0] thr_lo_i,
  input  logic [DATA_W-1:0] thr_hi_i,
  input  logic [2:0]        win_mode_i,
  input  logic              diff_mode_i,
  input  logic              flag_clr_i,
  output logic              match_flag_o,
  output logic              match_irq_o
);
  logic [DATA_W-1:0] thr [NUM_THR];
  cmp_res_t          cmp [NUM_THR];
  logic              hit;

  assign thr[THR_LO] = thr_lo_i;
  assign thr[THR_HI] = thr_hi_i;

  for (genvar g = 0; g < NUM_THR; g++) begin : g_cmp
    adc_win_cmp #(.DATA_W(DATA_W)) u_cmp (
      .val_i       (res_data_i),
      .ref_i       (thr[g]),
      .signed_en_i (diff_mode_i),
      .res_o       (cmp[g])
    );
  end

  adc_win_decode u_dec (
    .mode_i  (win_mode_i),
    .vs_lo_i (cmp[THR_LO]),
    .vs_hi_i (cmp[THR_HI]),
    .hit_o   (hit)
  );

  adc_win_flag u_flag (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .event_i (res_valid_i & hit),
    .clr_i   (flag_clr_i),
    .flag_o  (match_flag_o),
    .irq_o   (match_irq_o)
  );
endmodule

// File: rtl/adc_window_monitor_chk.sv
module adc_window_monitor_chk #(
  parameter int unsigned DATA_W = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              res_valid_i,
  input logic [DATA_W-1:0] res_data_i,
  input logic [DATA_W-1:0] thr_lo_i,
  input logic [DATA_W-1:0] thr_hi_i,
  input logic [2:0]        win_mode_i,
  input logic              diff_mode_i,
  input logic              flag_clr_i,
  input logic              match_flag_o,
  input logic              match_irq_o
);
  // R1 / R6: off and reserved codes never raise the pulse
  a_r6_off_no_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_i && (win_mode_i == 3'd0 || win_mode_i >= 3'd5)) |=> !match_irq_o);

  // R8: idle cycles raise no pulse
  a_r8_idle_no_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !res_valid_i |=> !match_irq_o);

  // R8: no clear and no result leave the flag unchanged
  a_r8_flag_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!res_valid_i && !flag_clr_i) |=> $stable(match_flag_o));

  // R9: a pulse is always accompanied by the flag
  a_r9_irq_sets_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_irq_o |-> match_flag_o);

  // R10: a clear with no result empties the flag
  a_r10_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_clr_i && !res_valid_i) |=> !match_flag_o);

  // R4: an unsigned result at or below the lower threshold misses the inside window
  a_r4_inside_low_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_i && win_mode_i == 3'd3 && !diff_mode_i && res_data_i <= thr_lo_i)
      |=> !match_irq_o);

  // R3: an unsigned result at or above the upper threshold misses mode 2
  a_r3_below_hi_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_i && win_mode_i == 3'd2 && !diff_mode_i && res_data_i >= thr_hi_i)
      |=> !match_irq_o);
endmodule

bind adc_window_monitor adc_window_monitor_chk #(.DATA_W(DATA_W)) chk_i (.*);

// File: tb/adc_window_monitor_tb_top.sv
module adc_window_monitor_tb_top;
  localparam int unsigned DATA_W = 12;
  localparam int unsigned MAX_CYC = 200000;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              valid = 1'b0;
  logic [DATA_W-1:0] res = '0;
  logic [DATA_W-1:0] lo = '0;
  logic [DATA_W-1:0] hi = '0;
  logic [2:0]        mode = '0;
  logic              diff = 1'b0;
  logic              clr = 1'b0;
  logic              flag;
  logic              irq;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done = 1'b0;
  logic exp_flag = 1'b0;

  always #2 clk = ~clk; // 250 MHz

  adc_window_monitor #(.DATA_W(DATA_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .res_valid_i(valid), .res_data_i(res),
    .thr_lo_i(lo), .thr_hi_i(hi), .win_mode_i(mode), .diff_mode_i(diff),
    .flag_clr_i(clr), .match_flag_o(flag), .match_irq_o(irq)
  );

  function automatic bit gt(logic [DATA_W-1:0] a, logic [DATA_W-1:0] b, bit sg);
    if (sg) return $signed(a) > $signed(b);
    return a > b;
  endfunction

  function automatic bit model_hit(logic [DATA_W-1:0] r, logic [DATA_W-1:0] l,
                                   logic [DATA_W-1:0] h, logic [2:0] m, bit sg);
    case (m)
      3'd1: return gt(r, l, sg);
      3'd2: return gt(h, r, sg);
      3'd3: return gt(r, l, sg) && gt(h, r, sg);
      3'd4: return gt(r, h, sg) && gt(l, r, sg);
      default: return 1'b0;
    endcase
  endfunction

  function automatic string tag_of(logic [2:0] m, bit sg);
    if (sg) return "R7";
    case (m)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic check(string tag, logic act, logic expv, string what);
    n_chk++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b", tag, what, act, expv);
    end
  endtask

  // drive one cycle at the falling edge, check just after the next rising edge
  task automatic step(bit v, logic [DATA_W-1:0] r, logic [DATA_W-1:0] l,
                      logic [DATA_W-1:0] h, logic [2:0] m, bit sg, bit c, string tag);
    bit e;
    @(negedge clk);
    valid = v; res = r; lo = l; hi = h; mode = m; diff = sg; clr = c;
    e = v && model_hit(r, l, h, m, sg);
    if (e) exp_flag = 1'b1;
    else if (c) exp_flag = 1'b0;
    @(posedge clk);
    #1;
    check(tag, irq, e, "irq");
    check(tag, flag, exp_flag, "flag");
  endtask

  function automatic logic [DATA_W-1:0] pick(logic [DATA_W-1:0] l, logic [DATA_W-1:0] h);
    case ($urandom % 6)
      0: return l;
      1: return h;
      2: return l + 1'b1;
      3: return h - 1'b1;
      default: return DATA_W'($urandom);
    endcase
  endfunction

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'h5EED_0A0C);
    repeat (3) @(posedge clk);
    #1;
    check("R1", flag, 1'b0, "reset flag");
    check("R1", irq, 1'b0, "reset irq");
    @(negedge clk);
    rst_n = 1'b1;

    // directed corner cases
    step(1, 12'd200, 12'd100, 12'd300, 3'd0, 0, 0, "R1");   // disabled, would match elsewhere
    step(1, 12'd100, 12'd100, 12'd300, 3'd1, 0, 0, "R2");   // equal to lower: no match
    step(1, 12'd101, 12'd100, 12'd300, 3'd1, 0, 0, "R2");   // just above: match
    step(0, 12'd0,   12'd0,   12'd0,   3'd0, 0, 1, "R10");  // clear
    step(1, 12'd300, 12'd100, 12'd300, 3'd2, 0, 0, "R3");   // equal to upper: no match
    step(1, 12'd299, 12'd100, 12'd300, 3'd3, 0, 0, "R4");   // inside
    step(1, 12'd299, 12'd100, 12'd300, 3'd3, 0, 0, "R9");   // back-to-back pulse
    step(0, 12'd0,   12'd0,   12'd0,   3'd0, 0, 0, "R9");   // pulse drops, flag holds
    step(1, 12'd75,  12'd100, 12'd50,  3'd4, 0, 1, "R10");  // swapped band hit with clear: stays
    step(0, 12'd0,   12'd0,   12'd0,   3'd0, 0, 1, "R10");
    step(1, 12'd50,  12'd100, 12'd50,  3'd4, 0, 0, "R5");   // on upper edge: no match
    step(0, 12'd200, 12'd100, 12'd300, 3'd3, 0, 0, "R8");   // no strobe: ignored
    step(1, 12'd200, 12'd100, 12'd300, 3'd5, 0, 0, "R6");
    step(1, 12'd200, 12'd100, 12'd300, 3'd7, 0, 0, "R6");
    step(1, 12'd0,   12'hFFF, 12'd5,   3'd1, 1, 0, "R7");   // 0 > -1 signed
    step(0, 12'd0,   12'd0,   12'd0,   3'd0, 0, 1, "R10");
    step(1, 12'd0,   12'hFFF, 12'd5,   3'd1, 0, 0, "R7");   // 0 > 4095 unsigned: no

    // constrained random
    for (int i = 0; i < 4000; i++) begin
      logic [DATA_W-1:0] l, h;
      logic [2:0] m;
      bit sg;
      l = DATA_W'($urandom);
      h = DATA_W'($urandom);
      m = 3'($urandom);
      sg = ($urandom % 3) == 0;
      step(($urandom % 4) != 0, pick(l, h), l, h, m, sg, ($urandom % 5) == 0, tag_of(m, sg));
    end

    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (MAX_CYC) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule